// File: doc/BRIEF.md
# Shared-Bus Master/Slave Port

This block sits between a microprogrammed processor and a shared bus where every transfer is timed by a strobe/acknowledge handshake rather than a common clock. It holds three 16-bit registers: an address register, a receive register and a transmit register. Any one of them can be selected onto an operand output that feeds the ALU.

As a bus master, the block raises a request to an external arbiter. It waits until it sees the grant, then presents the address and, for a write, the transmit data. It raises the strobe and waits for the target's acknowledge. On a read it captures the bus data into the receive register. It then drops the strobe and waits for the acknowledge to fall. Finally it pulses a completion flag back to the sequencer, so the sequencer stalls for exactly as long as the transfer takes.

While the processor is halted, the block also answers as a bus slave. Twelve internal processor registers occupy a contiguous word-aligned window that starts at a configurable base address. Other masters can read or write these registers through a simple register-file port. All incoming asynchronous handshake signals pass through synchronizer stages before any decision is made on them.

Top module: `xbus_port`

## Requirements
- R1: After reset, bus_req_o, bus_strb_o, bus_addr_oe_o, bus_data_oe_o, bus_ack_o, reg_we_o, done_o and busy_o are 0, and y_o is 0 for every ysel_i.
- R2: start_i in idle raises bus_req_o and busy_o. Neither bus_strb_o nor bus_addr_oe_o rises before bus_gnt_i has been seen high.
- R3: While bus_addr_oe_o is high, bus_addr_o equals the address register. Loads of the address and transmit registers (a_ld_i, t_ld_i) are ignored while busy_o is high.
- R4: A master read (wr_i=0 at start) stores the bus_data_i value present with the acknowledge into the receive register. That value is visible on y_o with ysel_i=2 once done_o has pulsed.
- R5: During a master write (wr_i=1 at start), the strobe phase shows bus_wr_o=1, bus_data_oe_o=1 and bus_data_o equal to the transmit register.
- R6: bus_strb_o stays high until an acknowledge is seen, then falls. done_o is a one-cycle pulse that occurs only after the acknowledge has fallen. bus_req_o and busy_o are low in the cycle done_o is high.
- R7: y_o selects by ysel_i: 0 gives zero, 1 the address register, 2 the receive register, 3 the transmit register.
- R8: While halted_i=1, a slave read at even address BASE_ADDR+2*i (i=0..11) selects register i on reg_sel_o. Indices 0-6 are the general registers, 7 the program counter, 8 status, 9 the instruction register, 10-11 the firmware registers. The block acknowledges with reg_rdata_i on bus_data_o and bus_data_oe_o=1.
- R9: While halted_i=1, a slave write in the window gives exactly one reg_we_o pulse with reg_sel_o=i and reg_wdata_o equal to the bus data, then an acknowledge.
- R10: A slave access to an odd address or to any address outside the twelve-word window gets no acknowledge and no reg_we_o.
- R11: A slave strobe that rises while halted_i=0 gets no acknowledge, even if halted_i rises while that strobe is still high.
- R12: The slave acknowledge stays high until the strobe falls, then drops. bus_data_oe_o is driven by the slave only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halted_i | input | 1 | Processor halted; enables slave access |
| start_i | input | 1 | Sequencer starts a master transfer |
| wr_i | input | 1 | Transfer direction at start, 1 = write |
| a_ld_i | input | 1 | Load address register |
| a_d_i | input | 16 | Address register load value |
| t_ld_i | input | 1 | Load transmit register |
| t_d_i | input | 16 | Transmit register load value |
| ysel_i | input | 2 | Operand select: 0 zero, 1 address, 2 receive, 3 transmit |
| y_o | output | 16 | Operand to ALU |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Master transfer in progress |
| bus_req_o | output | 1 | Request to arbiter |
| bus_gnt_i | input | 1 | Grant from arbiter (asynchronous) |
| bus_addr_o | output | 16 | Address driven as master |
| bus_addr_oe_o | output | 1 | Address drive enable |
| bus_wr_o | output | 1 | Master write qualifier |
| bus_strb_o | output | 1 | Master strobe |
| bus_ack_i | input | 1 | Acknowledge from target (asynchronous) |
| bus_data_i | input | 16 | Bus data in |
| bus_data_o | output | 16 | Bus data out (master write or slave read) |
| bus_data_oe_o | output | 1 | Data drive enable |
| bus_addr_i | input | 16 | Address from a foreign master |
| bus_wr_i | input | 1 | Foreign master write qualifier |
| bus_strb_i | input | 1 | Foreign master strobe (asynchronous) |
| bus_ack_o | output | 1 | Slave acknowledge |
| reg_sel_o | output | 4 | Processor register index |
| reg_we_o | output | 1 | Processor register write enable |
| reg_wdata_o | output | 16 | Processor register write data |
| reg_rdata_i | input | 16 | Processor register read data |

## Verification
A wrong master state shows at the ports within a few cycles. Examples are a strobe before the grant, a strobe that falls without an acknowledge, or a completion pulse while the acknowledge is still high. Each of these breaks the handshake that the bench's responder is following. A corrupted address, receive or transmit register shows on y_o in the very next cycle, because the bench compares that output against its own register model on every clock. Slave decode faults show as a missing or spurious acknowledge within the synchronizer latency plus two cycles, or as a wrong index or data on the register-file port. The bench checks these faults by reading values back through the bus.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {M_IDLE, M_REQ, M_SETUP, M_STRB, M_REL} mst_e;
  typedef enum logic [1:0] {S_IDLE, S_ACC, S_ACK} slv_e;
  typedef enum logic [1:0] {
    YSEL_NONE = 2'd0,
    YSEL_ADDR = 2'd1,
    YSEL_RECV = 2'd2,
    YSEL_XMIT = 2'd3
  } ysel_e;
endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic ff_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= 1'b0;
        else         ff_q <= d_i;
      assign q_o = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      assign q_o = ff_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wr_i,
  input  logic gnt_s_i,
  input  logic ack_s_i,
  output logic bus_req_o,
  output logic bus_strb_o,
  output logic bus_wr_o,
  output logic addr_oe_o,
  output logic data_oe_o,
  output logic r_ld_o,
  output logic done_o,
  output logic busy_o
);
  mst_e st_q, st_d;
  logic wr_q, done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      M_IDLE:  if (start_i) st_d = M_REQ;
      M_REQ:   if (gnt_s_i) st_d = M_SETUP;
      M_SETUP: st_d = M_STRB;               // address setup before strobe
      M_STRB:  if (ack_s_i) st_d = M_REL;
      M_REL:   if (!ack_s_i) st_d = M_IDLE;
      default: st_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      if (st_q == M_IDLE && start_i) wr_q <= wr_i;
      done_q <= (st_q == M_REL) && !ack_s_i;
    end
  end

  assign busy_o     = (st_q != M_IDLE);
  assign bus_req_o  = busy_o;
  assign bus_strb_o = (st_q == M_STRB);
  assign addr_oe_o  = (st_q == M_SETUP) || (st_q == M_STRB) || (st_q == M_REL);
  assign data_oe_o  = addr_oe_o && wr_q;
  assign bus_wr_o   = addr_oe_o && wr_q;
  assign r_ld_o     = (st_q == M_STRB) && ack_s_i && !wr_q;
  assign done_o     = done_q;

  a_r2_strb_after_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_strb_o) |-> gnt_s_i);
  a_r6_strb_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_strb_o && !ack_s_i) |=> bus_strb_o);
  a_r6_done_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ack_s_i && !bus_req_o));
endmodule

// File: rtl/xbus_slave.sv
module xbus_slave
  import xbus_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          NREGS     = 12,
  parameter logic [15:0] BASE_ADDR = 16'h0100,
  localparam int         SEL_W     = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halted_i,
  input  logic             strb_s_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             ack_o,
  output logic             data_oe_o,
  output logic [DW-1:0]    rdata_o,
  output logic [SEL_W-1:0] reg_sel_o,
  output logic             reg_we_o,
  output logic [DW-1:0]    reg_wdata_o,
  input  logic [DW-1:0]    reg_rdata_i
);
  localparam logic [AW-2:0] NREGS_W = (AW-1)'(NREGS);
  localparam logic [AW-2:0] BASE_W  = BASE_ADDR[AW-1:1];

  slv_e st_q;
  logic strb_d_q, wr_q;
  logic [SEL_W-1:0] idx_q;
  logic [DW-1:0] wd_q, rd_q;
  logic [AW-2:0] woff;
  logic hit, strb_rise;

  // unsigned offset: addresses below the base wrap high and miss
  assign woff      = addr_i[AW-1:1] - BASE_W;
  assign hit       = !addr_i[0] && (woff < NREGS_W);
  assign strb_rise = strb_s_i && !strb_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      strb_d_q <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
    end else begin
      strb_d_q <= strb_s_i;
      unique case (st_q)
        S_IDLE: if (strb_rise && halted_i && hit) begin
          st_q  <= S_ACC;
          wr_q  <= wr_i;
          idx_q <= woff[SEL_W-1:0];
          wd_q  <= wdata_i;
        end
        S_ACC: begin
          st_q <= S_ACK;
          if (!wr_q) rd_q <= reg_rdata_i;
        end
        S_ACK: if (!strb_s_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ack_o       = (st_q == S_ACK);
  assign data_oe_o   = ack_o && !wr_q;
  assign rdata_o     = rd_q;
  assign reg_sel_o   = idx_q;
  assign reg_we_o    = (st_q == S_ACC) && wr_q;
  assign reg_wdata_o = wd_q;

  a_r11_ack_needs_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(halted_i, 2));
  a_r12_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && strb_s_i) |=> ack_o);
  a_r10_sel_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (32'(reg_sel_o) < NREGS));
endmodule

// File: rtl/xbus_port.sv
module xbus_port
  import xbus_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          NREGS       = 12,
  parameter logic [15:0] BASE_ADDR   = 16'h0100,
  localparam int         AW          = 16,
  localparam int         DW          = 16,
  localparam int         SEL_W       = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halted_i,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic             a_ld_i,
  input  logic [AW-1:0]    a_d_i,
  input  logic             t_ld_i,
  input  logic [DW-1:0]    t_d_i,
  input  logic [1:0]       ysel_i,
  output logic [DW-1:0]    y_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic [AW-1:0]    bus_addr_o,
  output logic             bus_addr_oe_o,
  output logic             bus_wr_o,
  output logic             bus_strb_o,
  input  logic             bus_ack_i,
  input  logic [DW-1:0]    bus_data_i,
  output logic [DW-1:0]    bus_data_o,
  output logic             bus_data_oe_o,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_strb_i,
  output logic             bus_ack_o,
  output logic [SEL_W-1:0] reg_sel_o,
  output logic             reg_we_o,
  output logic [DW-1:0]    reg_wdata_o,
  input  logic [DW-1:0]    reg_rdata_i
);
  logic gnt_s, ack_s, strb_s;
  logic m_data_oe, s_data_oe, r_ld;
  logic [DW-1:0] s_rdata;
  logic [AW-1:0] a_q;
  logic [DW-1:0] r_q, t_q;

  xbus_sync #(.STAGES(SYNC_STAGES)) u_sync_gnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_gnt_i), .q_o(gnt_s));
  xbus_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_ack_i), .q_o(ack_s));
  xbus_sync #(.STAGES(SYNC_STAGES)) u_sync_strb (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_strb_i), .q_o(strb_s));

  xbus_master u_master (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .wr_i      (wr_i),
    .gnt_s_i   (gnt_s),
    .ack_s_i   (ack_s),
    .bus_req_o (bus_req_o),
    .bus_strb_o(bus_strb_o),
    .bus_wr_o  (bus_wr_o),
    .addr_oe_o (bus_addr_oe_o),
    .data_oe_o (m_data_oe),
    .r_ld_o    (r_ld),
    .done_o    (done_o),
    .busy_o    (busy_o)
  );

  xbus_slave #(
    .AW(AW), .DW(DW), .NREGS(NREGS), .BASE_ADDR(BASE_ADDR)
  ) u_slave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halted_i   (halted_i),
    .strb_s_i   (strb_s),
    .addr_i     (bus_addr_i),
    .wr_i       (bus_wr_i),
    .wdata_i    (bus_data_i),
    .ack_o      (bus_ack_o),
    .data_oe_o  (s_data_oe),
    .rdata_o    (s_rdata),
    .reg_sel_o  (reg_sel_o),
    .reg_we_o   (reg_we_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i)
  );

  // A and T frozen for the whole master transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      r_q <= '0;
      t_q <= '0;
    end else begin
      if (a_ld_i && !busy_o) a_q <= a_d_i;
      if (t_ld_i && !busy_o) t_q <= t_d_i;
      if (r_ld)              r_q <= bus_data_i;
    end
  end

  always_comb begin
    unique case (ysel_e'(ysel_i))
      YSEL_ADDR: y_o = a_q;
      YSEL_RECV: y_o = r_q;
      YSEL_XMIT: y_o = t_q;
      default:   y_o = '0;
    endcase
  end

  assign bus_addr_o    = a_q;
  assign bus_data_o    = m_data_oe ? t_q : s_rdata;
  assign bus_data_oe_o = m_data_oe || s_data_oe;

  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_oe_o |=> (!bus_addr_oe_o || $stable(bus_addr_o)));
  a_r12_oe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_data_oe && s_data_oe));
endmodule

// File: tb/xbus_port_tb.sv
module xbus_port_tb_top;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic halted_i = 1'b0, start_i = 1'b0, wr_i = 1'b0;
  logic a_ld_i = 1'b0, t_ld_i = 1'b0;
  logic [15:0] a_d_i = '0, t_d_i = '0;
  logic [1:0] ysel_i = 2'd0;
  logic [15:0] y_o;
  logic done_o, busy_o, bus_req_o, bus_gnt_i = 1'b0;
  logic [15:0] bus_addr_o;
  logic bus_addr_oe_o, bus_wr_o, bus_strb_o, bus_ack_i = 1'b0;
  logic [15:0] bus_data_i = '0, bus_data_o;
  logic bus_data_oe_o;
  logic [15:0] bus_addr_i = '0;
  logic bus_wr_i = 1'b0, bus_strb_i = 1'b0, bus_ack_o;
  logic [3:0] reg_sel_o;
  logic reg_we_o;
  logic [15:0] reg_wdata_o, reg_rdata_i;

  always #10 clk = ~clk;  // 50 MHz

  xbus_port #(.BASE_ADDR(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .halted_i(halted_i), .start_i(start_i), .wr_i(wr_i),
    .a_ld_i(a_ld_i), .a_d_i(a_d_i), .t_ld_i(t_ld_i), .t_d_i(t_d_i), .ysel_i(ysel_i),
    .y_o(y_o), .done_o(done_o), .busy_o(busy_o), .bus_req_o(bus_req_o),
    .bus_gnt_i(bus_gnt_i), .bus_addr_o(bus_addr_o), .bus_addr_oe_o(bus_addr_oe_o),
    .bus_wr_o(bus_wr_o), .bus_strb_o(bus_strb_o), .bus_ack_i(bus_ack_i),
    .bus_data_i(bus_data_i), .bus_data_o(bus_data_o), .bus_data_oe_o(bus_data_oe_o),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_strb_i(bus_strb_i),
    .bus_ack_o(bus_ack_o), .reg_sel_o(reg_sel_o), .reg_we_o(reg_we_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, we_cnt = 0;
  bit finished = 0;

  // processor register file model
  logic [15:0] rf [12];
  logic [3:0]  last_we_sel;
  assign reg_rdata_i = (reg_sel_o < 4'd12) ? rf[reg_sel_o] : 16'h0000;
  always @(posedge clk) if (reg_we_o) begin
    we_cnt <= we_cnt + 1;
    last_we_sel <= reg_sel_o;
    if (reg_sel_o < 4'd12) rf[reg_sel_o] <= reg_wdata_o;
  end

  // reference model of A/R/T
  logic [15:0] a_m = '0, r_m = '0, t_m = '0;
  bit busy_n = 0;
  always @(negedge clk) busy_n <= busy_o;
  always @(posedge clk) if (rst_ni && !busy_n) begin
    if (a_ld_i) a_m <= a_d_i;
    if (t_ld_i) t_m <= t_d_i;
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock operand compare (R7); R excluded while a read is in flight
  bit r_valid = 1;
  always @(negedge clk) if (rst_ni && !finished) begin
    logic [15:0] e;
    case (ysel_i)
      2'd1: e = a_m;
      2'd2: e = r_m;
      2'd3: e = t_m;
      default: e = 16'h0;
    endcase
    if (ysel_i != 2'd2 || r_valid) chk(y_o == e, "R7 operand per-clock", y_o, e);
  end

  task automatic master_xfer(input bit wr, input logic [15:0] addr, input logic [15:0] data, input int gnt_dly);
    int k;
    bit early;
    @(negedge clk);
    a_ld_i = 1; a_d_i = addr; wr_i = wr; start_i = 1;
    if (wr) begin t_ld_i = 1; t_d_i = data; end
    else r_valid = 0;
    @(negedge clk);
    a_ld_i = 0; t_ld_i = 0; start_i = 0;
    chk(bus_req_o && busy_o, "R2 request raised", {15'b0, bus_req_o}, 16'h1);
    // loads while busy must be ignored (R3)
    a_ld_i = 1; a_d_i = ~addr; t_ld_i = 1; t_d_i = ~data;
    @(negedge clk);
    a_ld_i = 0; t_ld_i = 0;
    early = 0;
    for (int i = 0; i < gnt_dly; i++) begin
      if (bus_strb_o || bus_addr_oe_o) early = 1;
      @(negedge clk);
    end
    chk(!early, "R2 no strobe before grant", {15'b0, early}, 16'h0);
    bus_gnt_i = 1;
    k = 0;
    while (!bus_strb_o && k < 20) begin @(negedge clk); k++; end
    chk(bus_strb_o, "R2 strobe after grant", {15'b0, bus_strb_o}, 16'h1);
    chk(bus_addr_oe_o && bus_addr_o == addr, "R3 bus address", bus_addr_o, addr);
    chk(bus_wr_o == wr, "R5 write qualifier", {15'b0, bus_wr_o}, {15'b0, wr});
    if (wr) chk(bus_data_oe_o && bus_data_o == data, "R5 write data", bus_data_o, data);
    early = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!bus_strb_o) early = 1;
    end
    chk(!early, "R6 strobe held until ack", {15'b0, early}, 16'h0);
    if (!wr) bus_data_i = data;
    bus_ack_i = 1;
    k = 0;
    while (bus_strb_o && k < 20) begin @(negedge clk); k++; end
    chk(!bus_strb_o, "R6 strobe drops after ack", {15'b0, bus_strb_o}, 16'h0);
    early = 0;
    for (int i = 0; i < 4; i++) begin
      if (done_o) early = 1;
      @(negedge clk);
    end
    chk(!early, "R6 no done while ack high", {15'b0, early}, 16'h0);
    bus_ack_i = 0;
    k = 0;
    while (!done_o && k < 20) begin @(negedge clk); k++; end
    chk(done_o && !bus_req_o && !busy_o, "R6 done pulse", {15'b0, done_o}, 16'h1);
    if (!wr) r_m = data;
    r_valid = 1;
    @(negedge clk);
    chk(!done_o, "R6 done one cycle", {15'b0, done_o}, 16'h0);
    bus_gnt_i = 0; bus_data_i = 16'h0;
    chk(a_m == addr, "R3 load ignored while busy", a_m, addr);
    if (!wr) begin
      ysel_i = 2'd2;
      #1 chk(y_o == data, "R4 receive register", y_o, data);
    end
  endtask

  task automatic slave_xfer(input bit wr, input logic [15:0] addr, input logic [15:0] wdata,
                            input bit exp_ack, input logic [15:0] exp_rd, input string tag);
    int k, we0;
    bit dropped;
    we0 = we_cnt;
    @(negedge clk);
    bus_addr_i = addr; bus_wr_i = wr; bus_data_i = wdata; bus_strb_i = 1;
    k = 0;
    while (!bus_ack_o && k < 12) begin @(negedge clk); k++; end
    if (exp_ack) begin
      chk(bus_ack_o, {tag, " ack"}, {15'b0, bus_ack_o}, 16'h1);
      if (!wr) chk(bus_data_oe_o && bus_data_o == exp_rd, {tag, " read data"}, bus_data_o, exp_rd);
      else begin
        chk(!bus_data_oe_o, "R12 no drive on write", {15'b0, bus_data_oe_o}, 16'h0);
        chk(we_cnt == we0 + 1 && last_we_sel == addr[4:1] - BASE[4:1],
            {tag, " single write pulse"}, 16'(we_cnt - we0), 16'h1);
      end
      dropped = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (!bus_ack_o) dropped = 1;
      end
      chk(!dropped, "R12 ack held while strobe", {15'b0, dropped}, 16'h0);
    end else begin
      chk(!bus_ack_o && we_cnt == we0, {tag, " no ack"}, {15'b0, bus_ack_o}, 16'h0);
    end
    bus_strb_i = 0;
    k = 0;
    while (bus_ack_o && k < 12) begin @(negedge clk); k++; end
    chk(!bus_ack_o && !bus_data_oe_o, "R12 ack released", {15'b0, bus_ack_o}, 16'h0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 12; i++) rf[i] = 16'(16'h1357 * (i + 1) ^ 16'h0F0F);
    repeat (3) @(negedge clk);
    chk(!bus_req_o && !bus_strb_o && !bus_addr_oe_o && !bus_data_oe_o && !bus_ack_o
        && !reg_we_o && !done_o && !busy_o, "R1 reset outputs", 16'h0, 16'h0);
    chk(y_o == 16'h0, "R1 reset operand", y_o, 16'h0);
    rst_ni = 1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      ysel_i = 2'(s);
      #1 chk(y_o == 16'h0, "R1 all operands zero", y_o, 16'h0);
    end
    ysel_i = 2'd1;
    master_xfer(0, 16'h4A52, 16'hBEEF, 6);
    ysel_i = 2'd3;
    master_xfer(1, 16'h8000, 16'h1234, 2);
    ysel_i = 2'd1;
    master_xfer(0, 16'hFFFE, 16'h0001, 0);
    ysel_i = 2'd3;
    #1 chk(y_o == 16'h1234, "R7 transmit select", y_o, 16'h1234);
    ysel_i = 2'd0;
    #1 chk(y_o == 16'h0, "R7 zero select", y_o, 16'h0);
    ysel_i = 2'd2;

    // slave while running: ignored (R11)
    slave_xfer(0, BASE, 16'h0, 0, 16'h0, "R11 running");
    @(negedge clk);
    bus_addr_i = BASE + 16'd4; bus_wr_i = 1; bus_data_i = 16'hDEAD; bus_strb_i = 1;
    repeat (4) @(negedge clk);
    halted_i = 1;
    begin
      bit any;
      any = 0;
      for (int i = 0; i < 10; i++) begin
        if (bus_ack_o || reg_we_o) any = 1;
        @(negedge clk);
      end
      chk(!any, "R11 late halt ignored", {15'b0, any}, 16'h0);
    end
    bus_strb_i = 0;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 12; i++)
      slave_xfer(0, BASE + 16'(2 * i), 16'h0, 1, rf[i], "R8 slave read");
    slave_xfer(1, BASE + 16'd14, 16'hA5C3, 1, 16'h0, "R9 slave write pc");
    chk(rf[7] == 16'hA5C3, "R9 register updated", rf[7], 16'hA5C3);
    slave_xfer(0, BASE + 16'd14, 16'h0, 1, 16'hA5C3, "R9 readback");
    slave_xfer(1, BASE + 16'd22, 16'h0F1E, 1, 16'h0, "R9 slave write fw");
    slave_xfer(0, BASE + 16'd22, 16'h0, 1, 16'h0F1E, "R9 readback fw");
    slave_xfer(1, BASE + 16'd24, 16'h7777, 0, 16'h0, "R10 past window");
    slave_xfer(0, BASE - 16'd2, 16'h0, 0, 16'h0, "R10 below base");
    slave_xfer(1, BASE + 16'd3, 16'h6666, 0, 16'h0, "R10 odd address");
    chk(rf[1] != 16'h6666 && rf[0] != 16'h7777, "R10 file untouched", rf[1], 16'h0);
    halted_i = 0;
    ysel_i = 2'd2;
    master_xfer(0, 16'h0002, 16'h5A5A, 3);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule